// File: doc/BRIEF.md
# Dual-Modulus Swallow Counter Controller

This block is the programmable part of a frequency synthesizer's feedback divider when an external dual-modulus prescaler sits between the VCO and the logic. It runs on the prescaler's output, which is the divided VCO clock. Two down-counters share that clock. The main counter sets the length of one divide cycle in prescaler output edges. The swallow counter sets how many of those edges are taken with the prescaler in its larger modulus.

The `modulus_hi` output steers the prescaler. While it is low, the prescaler divides by P+1. While it is high, it divides by P. Each divide cycle begins with `modulus_hi` low. The output goes high once the swallow count is used up and stays high until the main count ends. One divide cycle therefore spans N·P + A VCO periods. At the edge that closes a cycle, both counters reload from the programmed ratio inputs and `fb_pulse` goes high for one clock. That pulse is the feedback event for the phase detector.

The programmed ratios come from holding latches outside the block. The block reads them only at a reload, so a write that arrives partway through a cycle cannot corrupt the cycle in progress.

Top module: `dm_swallow_div`

## Requirements
- R1: While `rst` is high at a clock edge, `fb_pulse` is 0 and `ratio_clamped` is 0 after that edge. Both counters load the programmed ratios. `modulus_hi` is 1 exactly when `swallow_ratio` is 0.
- R2: After reset, each divide cycle lasts exactly N_eff rising edges of `clk`. `fb_pulse` is high for the single clock that follows the edge ending the cycle, and is low on the next clock.
- R3: Within a cycle with A ≤ N_eff, `modulus_hi` is low for the first A clock periods and high for the remaining N_eff − A periods.
- R4: With `swallow_ratio` = 0, `modulus_hi` is high for the whole cycle, starting with its first period.
- R5: With A equal to N_eff, `modulus_hi` stays low for the whole cycle.
- R6: `modulus_hi` goes from 1 to 0 only at the start of a cycle, in the same clock in which `fb_pulse` is high.
- R7: A change of `main_ratio` or `swallow_ratio` in the middle of a cycle has no effect on that cycle. The new values govern the cycle that starts at the next reload.
- R8: A `main_ratio` below 3 is illegal and is used as 3, so N_eff = max(`main_ratio`, 3). `ratio_clamped` is 1 one clock after any edge at which `main_ratio` is below 3, and 0 otherwise.
- R9: Count each period in which `modulus_hi` is low as P+1 input periods, and each high period as P. The sum over one divide cycle is then N_eff·P + A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaler output (divided VCO clock); every rising edge is one count |
| rst | input | 1 | Synchronous active-high reset; loads both counters |
| main_ratio | input | 10 | Programmed main division N (legal 3..1023) |
| swallow_ratio | input | 7 | Programmed swallow count A (0..127, A ≤ N) |
| modulus_hi | output | 1 | Prescaler modulus select: 0 selects P+1, 1 selects P |
| fb_pulse | output | 1 | One-clock pulse after the edge that ends each divide cycle |
| ratio_clamped | output | 1 | Registered flag: `main_ratio` was below 3 at the last edge |

## Verification
The main counter's terminal edge, which reloads both counters and raises `fb_pulse`, can fall in the same edge as the end of the swallow count. The case A equal to N forces this overlap. The bench also provokes it with A = 0, where the reload and the switch to the small modulus happen together, and with a ratio change written exactly mid-cycle just before a reload. In each case the bench counts the periods of the cycle and the periods in which `modulus_hi` is low, then compares both counts with N_eff and A. It also checks that `modulus_hi` never falls anywhere except on a reload.

// File: rtl/dmsc_pkg.sv
package dmsc_pkg;
  // Default widths and limits shared by the divider and its checker.
  localparam int DEF_MAIN_W   = 10;
  localparam int DEF_SWAL_W   = 7;
  localparam int DEF_MAIN_MIN = 3;
endpackage

// File: rtl/dmsc_ratio_guard.sv
module dmsc_ratio_guard #(
  parameter int MAIN_W   = dmsc_pkg::DEF_MAIN_W,
  parameter int SWAL_W   = dmsc_pkg::DEF_SWAL_W,
  parameter int MAIN_MIN = dmsc_pkg::DEF_MAIN_MIN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MAIN_W-1:0] main_ratio,
  input  logic [SWAL_W-1:0] swallow_ratio,
  output logic [MAIN_W-1:0] main_eff,
  output logic [SWAL_W-1:0] swal_eff,
  output logic              clamped
);
  localparam logic [MAIN_W-1:0] MIN_V = MAIN_W'(MAIN_MIN);

  logic too_small;

  assign too_small = (main_ratio < MIN_V);
  assign main_eff  = too_small ? MIN_V : main_ratio;
  assign swal_eff  = swallow_ratio;

  always_ff @(posedge clk) begin
    if (rst) clamped <= 1'b0;
    else     clamped <= too_small;
  end
endmodule

// File: rtl/dmsc_main_cnt.sv
module dmsc_main_cnt #(
  parameter int MAIN_W = dmsc_pkg::DEF_MAIN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MAIN_W-1:0] main_eff,
  output logic              wrap
);
  localparam logic [MAIN_W-1:0] ONE = MAIN_W'(1);

  logic [MAIN_W-1:0] remain;

  // Terminal at one: the edge that consumes the last count also reloads.
  assign wrap = !rst && (remain == ONE);

  always_ff @(posedge clk) begin
    if (rst || wrap) remain <= main_eff;
    else             remain <= remain - ONE;
  end
endmodule

// File: rtl/dmsc_swallow_cnt.sv
module dmsc_swallow_cnt #(
  parameter int SWAL_W = dmsc_pkg::DEF_SWAL_W
) (
  input  logic              clk,
  input  logic              load,
  input  logic [SWAL_W-1:0] swal_eff,
  output logic              zero_next
);
  localparam logic [SWAL_W-1:0] ONE = SWAL_W'(1);

  logic [SWAL_W-1:0] left;
  logic [SWAL_W-1:0] left_nx;

  always_comb begin
    if (load)              left_nx = swal_eff;
    else if (left != '0)   left_nx = left - ONE;
    else                   left_nx = '0;
  end

  assign zero_next = (left_nx == '0);

  always_ff @(posedge clk) begin
    left <= left_nx;
  end
endmodule

// File: rtl/dm_swallow_div.sv
module dm_swallow_div #(
  parameter int MAIN_W   = dmsc_pkg::DEF_MAIN_W,
  parameter int SWAL_W   = dmsc_pkg::DEF_SWAL_W,
  parameter int MAIN_MIN = dmsc_pkg::DEF_MAIN_MIN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MAIN_W-1:0] main_ratio,
  input  logic [SWAL_W-1:0] swallow_ratio,
  output logic              modulus_hi,
  output logic              fb_pulse,
  output logic              ratio_clamped
);
  logic [MAIN_W-1:0] main_eff;
  logic [SWAL_W-1:0] swal_eff;
  logic              wrap;
  logic              reload;
  logic              swal_zero_nx;

  dmsc_ratio_guard #(
    .MAIN_W(MAIN_W), .SWAL_W(SWAL_W), .MAIN_MIN(MAIN_MIN)
  ) u_guard (
    .clk(clk), .rst(rst),
    .main_ratio(main_ratio), .swallow_ratio(swallow_ratio),
    .main_eff(main_eff), .swal_eff(swal_eff), .clamped(ratio_clamped)
  );

  dmsc_main_cnt #(.MAIN_W(MAIN_W)) u_main (
    .clk(clk), .rst(rst), .main_eff(main_eff), .wrap(wrap)
  );

  assign reload = rst | wrap;

  dmsc_swallow_cnt #(.SWAL_W(SWAL_W)) u_swal (
    .clk(clk), .load(reload), .swal_eff(swal_eff), .zero_next(swal_zero_nx)
  );

  // Registered outputs: the modulus level is taken from the swallow
  // counter's next value so it changes on the same edge as the count.
  always_ff @(posedge clk) begin
    if (rst) fb_pulse <= 1'b0;
    else     fb_pulse <= wrap;
    modulus_hi <= swal_zero_nx;
  end
endmodule

// File: rtl/dmsc_checker.sv
module dmsc_checker #(
  parameter int MAIN_W   = dmsc_pkg::DEF_MAIN_W,
  parameter int SWAL_W   = dmsc_pkg::DEF_SWAL_W,
  parameter int MAIN_MIN = dmsc_pkg::DEF_MAIN_MIN
) (
  input logic              clk,
  input logic              rst,
  input logic [MAIN_W-1:0] main_ratio,
  input logic [SWAL_W-1:0] swallow_ratio,
  input logic              modulus_hi,
  input logic              fb_pulse,
  input logic              ratio_clamped
);
  localparam int CW = MAIN_W + 1;
  localparam logic [MAIN_W-1:0] MIN_V = MAIN_W'(MAIN_MIN);
  localparam logic [CW-1:0]     C_ONE = CW'(1);

  logic [MAIN_W-1:0] prev_main;
  logic [SWAL_W-1:0] prev_swal;
  logic [MAIN_W-1:0] cur_n;
  logic [SWAL_W-1:0] cur_a;
  logic [CW-1:0]     edge_cnt;
  logic [CW-1:0]     low_cnt;

  // Shadow model: which ratios the current cycle was loaded with,
  // how many periods it has had, and how many of them were low.
  always_ff @(posedge clk) begin
    prev_main <= main_ratio;
    prev_swal <= swallow_ratio;
    if (rst) begin
      cur_n    <= (main_ratio < MIN_V) ? MIN_V : main_ratio;
      cur_a    <= swallow_ratio;
      edge_cnt <= '0;
      low_cnt  <= '0;
    end else if (fb_pulse) begin
      cur_n    <= (prev_main < MIN_V) ? MIN_V : prev_main;
      cur_a    <= prev_swal;
      edge_cnt <= C_ONE;
      low_cnt  <= modulus_hi ? '0 : C_ONE;
    end else begin
      edge_cnt <= edge_cnt + C_ONE;
      low_cnt  <= low_cnt + (modulus_hi ? '0 : C_ONE);
    end
  end

  // R2: feedback pulse lasts a single clock
  p_fb_single_r2: assert property (@(posedge clk) disable iff (rst)
    fb_pulse |=> !fb_pulse);

  // R2, R7: cycle length equals the ratio captured at the reload
  p_cycle_len_r2: assert property (@(posedge clk) disable iff (rst)
    fb_pulse |-> (edge_cnt == {1'b0, cur_n}));

  // R3: low-modulus periods in a cycle equal the swallow count
  p_low_periods_r3: assert property (@(posedge clk) disable iff (rst)
    (fb_pulse && ({{(MAIN_W-SWAL_W){1'b0}}, cur_a} <= cur_n))
      |-> (low_cnt == {{(CW-SWAL_W){1'b0}}, cur_a}));

  // R6: modulus falls only at a cycle start
  p_mod_fall_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(modulus_hi)) |-> fb_pulse);

  // R8: clamp flag follows an illegal main ratio by one clock
  p_clamp_flag_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (ratio_clamped == ($past(main_ratio) < MIN_V)));
endmodule

bind dm_swallow_div dmsc_checker #(
  .MAIN_W(MAIN_W), .SWAL_W(SWAL_W), .MAIN_MIN(MAIN_MIN)
) u_chk (
  .clk(clk), .rst(rst),
  .main_ratio(main_ratio), .swallow_ratio(swallow_ratio),
  .modulus_hi(modulus_hi), .fb_pulse(fb_pulse),
  .ratio_clamped(ratio_clamped)
);

// File: tb/test_dm_swallow_div.sv
module test_dm_swallow_div;
  localparam int CLK_PERIOD = 10;
  localparam int PSC_P      = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] main_ratio = 10'd20;
  logic [6:0] swallow_ratio = 7'd5;
  logic       modulus_hi;
  logic       fb_pulse;
  logic       ratio_clamped;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  dm_swallow_div i_dm_swallow_div (
    .clk(clk), .rst(rst),
    .main_ratio(main_ratio), .swallow_ratio(swallow_ratio),
    .modulus_hi(modulus_hi), .fb_pulse(fb_pulse),
    .ratio_clamped(ratio_clamped)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int eff_n(int n);
    return (n < 3) ? 3 : n;
  endfunction

  task automatic sync_fb();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!fb_pulse && guard < 5000);
  endtask

  // Entered at a negedge where fb_pulse is high; runs one whole cycle.
  task automatic measure(output int edges, output int lows, output int falls,
                         input int chg_at, input int new_n, input int new_a);
    logic prev;
    edges = 0; lows = 0; falls = 0;
    prev = modulus_hi;
    forever begin
      if (edges == chg_at) begin
        main_ratio    = 10'(new_n);
        swallow_ratio = 7'(new_a);
      end
      if (!modulus_hi) lows++;
      if (edges > 0 && prev && !modulus_hi) falls++;
      prev = modulus_hi;
      edges++;
      @(negedge clk);
      if (fb_pulse || edges > 4000) break;
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    main_ratio = 10'd20;
    swallow_ratio = 7'd5;
    repeat (3) @(negedge clk);
    check("R1", "fb_pulse in reset", int'(fb_pulse), 0);
    check("R1", "modulus_hi in reset A=5", int'(modulus_hi), 0);
    check("R1", "ratio_clamped in reset", int'(ratio_clamped), 0);
    swallow_ratio = 7'd0;
    @(negedge clk);
    check("R1", "modulus_hi in reset A=0", int'(modulus_hi), 1);
    swallow_ratio = 7'd5;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_case(int n, int a, string tag);
    int edges, lows, falls;
    int ne;
    ne = eff_n(n);
    main_ratio    = 10'(n);
    swallow_ratio = 7'(a);
    sync_fb();
    measure(edges, lows, falls, -1, 0, 0);
    check("R2", $sformatf("%s cycle length", tag), edges, ne);
    check(tag, "low-modulus periods", lows, a);
    check("R6", $sformatf("%s falls mid-cycle", tag), falls, 0);
    check("R9", $sformatf("%s input periods", tag),
          lows * (PSC_P + 1) + (edges - lows) * PSC_P, ne * PSC_P + a);
    @(negedge clk);
    check("R2", $sformatf("%s fb_pulse width", tag), int'(fb_pulse), 0);
  endtask

  task automatic t_midchange();
    int edges, lows, falls;
    main_ratio    = 10'd12;
    swallow_ratio = 7'd4;
    sync_fb();
    measure(edges, lows, falls, 3, 30, 10);
    check("R7", "old cycle length after write", edges, 12);
    check("R7", "old swallow after write", lows, 4);
    measure(edges, lows, falls, -1, 0, 0);
    check("R7", "new cycle length", edges, 30);
    check("R7", "new swallow", lows, 10);
  endtask

  task automatic t_small_n();
    int edges, lows, falls;
    main_ratio    = 10'd1;
    swallow_ratio = 7'd0;
    @(negedge clk);
    check("R8", "flag with N=1", int'(ratio_clamped), 1);
    sync_fb();
    measure(edges, lows, falls, -1, 0, 0);
    check("R8", "N=1 length", edges, 3);
    main_ratio    = 10'd0;
    swallow_ratio = 7'd2;
    sync_fb();
    measure(edges, lows, falls, -1, 0, 0);
    check("R8", "N=0 length", edges, 3);
    check("R8", "N=0 swallow", lows, 2);
    main_ratio = 10'd3;
    @(negedge clk);
    check("R8", "flag with N=3", int'(ratio_clamped), 0);
    run_case(3, 3, "R5");
  endtask

  initial begin
    t_reset();
    run_case(20, 5, "R3");
    run_case(10, 0, "R4");
    run_case(9, 9, "R5");
    run_case(64, 1, "R3");
    run_case(1023, 127, "R3");
    t_midchange();
    t_small_n();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule